// File: doc/BRIEF.md
# Memory Attribute Type Resolver

The resolver turns a physical address into the caching type that governs it. Two kinds of table drive the answer. The first is a partitioned table of 88 type bytes that covers the first megabyte. The second is a parameterised set of variable windows, each made of a base and a mask. A single write port loads every table entry, the default type, the two enable bits and an optional upper-memory limit. The lookup port takes an address with a strobe and answers one cycle later.

Inside the first megabyte, the partitioned table wins when it is enabled. Above that, every enabled variable window whose masked base equals the masked address takes part. When windows overlap, the result follows caching precedence rather than the first match: uncacheable dominates, and write-back mixed with write-through gives write-through. An address that no window covers falls back to the default type. A nonzero upper-memory limit forces write-back on addresses from 4 GiB up to, but not including, that limit. When the global enable is clear, every lookup returns the disabled code 0xFF.

Top module: `mem_type_resolver`

## Requirements
- R1: While `rst_n` is low and after reset, `rsp_valid` is low and all configuration is cleared, so a first lookup returns 0xFF.
- R2: `rsp_valid` is high exactly one cycle after `lk_valid`, carrying the type for the address given with that strobe; strobes on consecutive cycles give consecutive responses.
- R3: Configuration write select 3 loads the default type from data bits [7:0], the fixed enable from bit 10 and the global enable from bit 11; with the global enable clear every lookup returns 0xFF.
- R4: For addresses below 0x80000, the type is fixed byte index addr[18:16] (64 KiB granules). Select 0 writes fixed byte `cfg_idx` from data bits [7:0].
- R5: For addresses 0x80000 to 0xBFFFF, the type is fixed byte 8 + addr[17:14] (16 KiB granules).
- R6: For addresses 0xC0000 to 0xFFFFF, the type is fixed byte 24 + addr[17:12] (4 KiB granules).
- R7: Below 1 MiB, with fixed support, the global enable and the fixed enable all set, the fixed byte is returned and variable windows have no effect; with the fixed enable clear, such addresses resolve through the variable windows.
- R8: Select 1 loads window `cfg_idx` base (address bits [ADDR_W-1:12], type in bits [7:0]). Select 2 loads its mask (bits [ADDR_W-1:12]) and its enable (bit 11). A window takes part only when that enable is set, and it matches when the masked address equals the masked base.
- R9: With several matching windows, any uncacheable (0) gives 0; write-back (6) with write-through (4) gives 4; equal types keep that type; any other differing pair gives 0.
- R10: When no window matches, the default type is returned.
- R11: Select 4 loads the upper-memory limit. When the limit is nonzero, an address at or above 4 GiB and below the limit returns write-back (6); the limit itself is outside this range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0 fixed byte, 1 window base, 2 window mask, 3 default/enables, 4 upper limit |
| cfg_idx | input | IDX_W | Fixed byte or window index |
| cfg_wdata | input | ADDR_W | Write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | ADDR_W | Lookup physical address |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_type | output | 8 | Resolved type, or 0xFF when disabled |

## Verification
A stale or corrupted table entry shows up only on the response that follows a lookup in the affected granule or window. It therefore appears on `rsp_type` exactly one cycle after the strobe for that address. Faults in the overlap merge appear only when two or more windows cover the same address, so the stimulus stacks windows of different types on shared addresses. Index arithmetic faults show up at the granule edges of each fixed region, so lookups probe the first and last granule of each region.

// File: rtl/mtr_pkg.sv
// Package: shared type codes, write selects and the overlap merge rule.
// Assumes 8-bit type codes; 0xFF is reserved for "unit disabled".
package mtr_pkg;
    localparam logic [7:0] MT_UC  = 8'h00;
    localparam logic [7:0] MT_WC  = 8'h01;
    localparam logic [7:0] MT_WT  = 8'h04;
    localparam logic [7:0] MT_WP  = 8'h05;
    localparam logic [7:0] MT_WB  = 8'h06;
    localparam logic [7:0] MT_INV = 8'hFF;

    localparam int FIX_N  = 88;
    localparam int PAGE_B = 12;

    typedef enum logic [2:0] {
        SEL_FIX   = 3'd0,
        SEL_VBASE = 3'd1,
        SEL_VMASK = 3'd2,
        SEL_DEF   = 3'd3,
        SEL_TOP2  = 3'd4
    } cfg_sel_e;

    // Precedence merge of two matching window types.
    function automatic logic [7:0] merge_types(input logic [7:0] a, input logic [7:0] b);
        if (a == MT_UC || b == MT_UC) return MT_UC;
        if (a == b) return a;
        if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB)) return MT_WT;
        return MT_UC;
    endfunction
endpackage

// File: rtl/mtr_cfg_regs.sv
// Configuration storage: fixed type bytes, window base/mask fields,
// default type with enables, and the upper-memory limit.
// Assumes one write per cycle; out-of-range indices are dropped.
module mtr_cfg_regs
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8,
    parameter int IDX_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_sel,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [ADDR_W-1:0]        cfg_wdata,
    output logic [7:0]               fix_tbl   [FIX_N],
    output logic [ADDR_W-PAGE_B-1:0] var_page  [NUM_VAR],
    output logic [7:0]               var_type  [NUM_VAR],
    output logic [ADDR_W-PAGE_B-1:0] var_mpage [NUM_VAR],
    output logic                     var_on    [NUM_VAR],
    output logic [7:0]               def_type,
    output logic                     glb_en,
    output logic                     fix_en,
    output logic [ADDR_W-1:0]        top2
);
    // Fixed type bytes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < FIX_N; i++) begin
            if (!rst_n)
                fix_tbl[i] <= '0;
            else if (cfg_we && cfg_sel == SEL_FIX && cfg_idx == IDX_W'(i))
                fix_tbl[i] <= cfg_wdata[7:0];
        end
    end

    // Variable window fields.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_VAR; i++) begin
            if (!rst_n) begin
                var_page[i]  <= '0;
                var_type[i]  <= '0;
                var_mpage[i] <= '0;
                var_on[i]    <= 1'b0;
            end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
                if (cfg_sel == SEL_VBASE) begin
                    var_page[i] <= cfg_wdata[ADDR_W-1:PAGE_B];
                    var_type[i] <= cfg_wdata[7:0];
                end
                if (cfg_sel == SEL_VMASK) begin
                    var_mpage[i] <= cfg_wdata[ADDR_W-1:PAGE_B];
                    var_on[i]    <= cfg_wdata[11];
                end
            end
        end
    end

    // Default type, enables and upper-memory limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            def_type <= '0;
            glb_en   <= 1'b0;
            fix_en   <= 1'b0;
            top2     <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_DEF) begin
                def_type <= cfg_wdata[7:0];
                fix_en   <= cfg_wdata[10];
                glb_en   <= cfg_wdata[11];
            end
            if (cfg_sel == SEL_TOP2)
                top2 <= cfg_wdata;
        end
    end
endmodule

// File: rtl/mtr_fixed_lookup.sv
// Fixed-table index: 64 KiB, 16 KiB and 4 KiB granule regions in the
// first megabyte. Assumes the caller has already checked addr < 1 MiB.
module mtr_fixed_lookup
    import mtr_pkg::*;
(
    input  logic [19:12] addr_pg,
    input  logic [7:0]   fix_tbl [FIX_N],
    output logic [7:0]   fix_type
);
    logic [6:0] idx;

    // Select the granule index from the region the address falls in.
    always_comb begin
        if (!addr_pg[19])
            idx = {4'b0, addr_pg[18:16]};
        else if (!addr_pg[18])
            idx = 7'd8 + {3'b0, addr_pg[17:14]};
        else
            idx = 7'd24 + {1'b0, addr_pg[17:12]};
    end

    // Read the type byte.
    assign fix_type = fix_tbl[idx];
endmodule

// File: rtl/mtr_var_lookup.sv
// Variable windows: per-window masked compare, then a precedence fold of
// every matching type. Assumes page-granular compare (bits below 12 ignored).
module mtr_var_lookup
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input  logic [ADDR_W-PAGE_B-1:0] addr_pg,
    input  logic [ADDR_W-PAGE_B-1:0] var_page  [NUM_VAR],
    input  logic [7:0]               var_type  [NUM_VAR],
    input  logic [ADDR_W-PAGE_B-1:0] var_mpage [NUM_VAR],
    input  logic                     var_on    [NUM_VAR],
    output logic                     any_hit,
    output logic [7:0]               var_res
);
    logic [NUM_VAR-1:0] hit;

    // One comparator per window.
    for (genvar g = 0; g < NUM_VAR; g++) begin : g_cmp
        assign hit[g] = var_on[g] && (((addr_pg ^ var_page[g]) & var_mpage[g]) == '0);
    end

    // Fold all matching types under the precedence rule.
    always_comb begin
        any_hit = 1'b0;
        var_res = MT_INV;
        for (int i = 0; i < NUM_VAR; i++) begin
            if (hit[i]) begin
                var_res = any_hit ? merge_types(var_res, var_type[i]) : var_type[i];
                any_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mem_type_resolver.sv
// Top: configuration store plus fixed and variable lookups, priority
// selection and one response register. Assumes ADDR_W > 32 so the
// 4 GiB bound of the upper-memory window is representable.
module mem_type_resolver
    import mtr_pkg::*;
#(
    parameter int ADDR_W    = 36,
    parameter int NUM_VAR   = 8,
    parameter bit HAS_FIXED = 1'b1,
    localparam int VIDX_W   = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1,
    localparam int IDX_W    = (VIDX_W > 7) ? VIDX_W : 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic [7:0]        rsp_type
);
    logic [7:0]               fix_tbl   [FIX_N];
    logic [ADDR_W-PAGE_B-1:0] var_page  [NUM_VAR];
    logic [7:0]               var_type  [NUM_VAR];
    logic [ADDR_W-PAGE_B-1:0] var_mpage [NUM_VAR];
    logic                     var_on    [NUM_VAR];
    logic [7:0]               def_type;
    logic                     glb_en;
    logic                     fix_en;
    logic [ADDR_W-1:0]        top2;
    logic [7:0]               fixed_type;
    logic [7:0]               var_res;
    logic                     var_any;
    logic                     fixed_sel;
    logic                     top2_win;
    logic [7:0]               next_type;

    mtr_cfg_regs #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .IDX_W(IDX_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .fix_tbl(fix_tbl),
        .var_page(var_page), .var_type(var_type), .var_mpage(var_mpage),
        .var_on(var_on), .def_type(def_type), .glb_en(glb_en),
        .fix_en(fix_en), .top2(top2)
    );

    mtr_fixed_lookup fix_i (
        .addr_pg(lk_addr[19:12]), .fix_tbl(fix_tbl), .fix_type(fixed_type)
    );

    mtr_var_lookup #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) var_i (
        .addr_pg(lk_addr[ADDR_W-1:PAGE_B]), .var_page(var_page),
        .var_type(var_type), .var_mpage(var_mpage), .var_on(var_on),
        .any_hit(var_any), .var_res(var_res)
    );

    // Fixed table owns the first megabyte when supported and enabled.
    assign fixed_sel = HAS_FIXED && fix_en && (lk_addr[ADDR_W-1:20] == '0);

    // Upper-memory write-back window: [4 GiB, top2).
    assign top2_win = (top2 != '0) && (lk_addr[ADDR_W-1:32] != '0) && (lk_addr < top2);

    // Priority: disabled, fixed, upper window, windows, default.
    always_comb begin
        if (!glb_en)        next_type = MT_INV;
        else if (fixed_sel) next_type = fixed_type;
        else if (top2_win)  next_type = MT_WB;
        else if (var_any)   next_type = var_res;
        else                next_type = def_type;
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_type  <= MT_INV;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) rsp_type <= next_type;
        end
    end
endmodule

// File: rtl/mtr_checker.sv
// Checker: timing and priority properties of the resolver, bound to the top.
module mtr_checker
    import mtr_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rsp_valid,
    input logic [7:0]        rsp_type,
    input logic              glb_en,
    input logic              fixed_sel,
    input logic [7:0]        fixed_type,
    input logic              var_any,
    input logic [7:0]        def_type,
    input logic [ADDR_W-1:0] top2
);
    logic in_top2;
    assign in_top2 = (top2 != '0) && (lk_addr >= ADDR_W'(64'h1_0000_0000)) && (lk_addr < top2);

    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    assert_disabled_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !glb_en) |=> rsp_type == MT_INV);

    assert_fixed_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && glb_en && fixed_sel) |=> rsp_type == $past(fixed_type));

    assert_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && glb_en && !fixed_sel && !var_any && !in_top2) |=> rsp_type == $past(def_type));

    assert_upper_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && glb_en && !fixed_sel && in_top2) |=> rsp_type == MT_WB);
endmodule

bind mem_type_resolver mtr_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .glb_en(glb_en),
    .fixed_sel(fixed_sel), .fixed_type(fixed_type), .var_any(var_any),
    .def_type(def_type), .top2(top2)
);

// File: tb/mem_type_resolver_tb_top.sv
// Scoreboard bench: the driver queues hand-computed expected types and the
// monitor compares each response as it appears.
module mem_type_resolver_tb_top;
    localparam int ADDR_W = 36;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_sel = '0;
    logic [6:0]        cfg_idx = '0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              rsp_valid;
    logic [7:0]        rsp_type;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] t;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    mem_type_resolver #(.ADDR_W(ADDR_W), .NUM_VAR(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_type(rsp_type)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input int idx, input logic [ADDR_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 7'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one strobe; caller calls idle() to end a burst.
    task automatic lookup(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        x.t = e; x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic idle();
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic probe(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
        lookup(a, e, tag);
        idle();
    endtask

    // Monitor: one response per queued expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected response", rsp_type, 8'h00);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                chk(rsp_type == x.t, x.tag, rsp_type, x.t);
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            chk(1'b0, "watchdog", 8'h00, 8'h00);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 valid low in reset", {7'b0, rsp_valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 valid low after reset", {7'b0, rsp_valid}, 8'h00);
        probe(36'h0, 8'hFF, "R1 cleared config gives disabled code");

        // Global on, fixed off, default WB: low address via windows -> default.
        cfg(3'd3, 0, 36'h806);
        probe(36'h1000, 8'h06, "R10/R7 default with fixed enable clear");

        // Fixed bytes.
        cfg(3'd0, 3,  36'h01);
        cfg(3'd0, 13, 36'h04);
        cfg(3'd0, 87, 36'h05);
        cfg(3'd0, 24, 36'h03);
        cfg(3'd0, 7,  36'h06);
        cfg(3'd3, 0, 36'hC00);
        probe(36'h30000, 8'h01, "R4 first byte of granule 3");
        probe(36'h3FFFF, 8'h01, "R4 last byte of granule 3");
        probe(36'h7F000, 8'h06, "R4 granule 7");
        probe(36'h00000, 8'h00, "R4 granule 0 unwritten");
        probe(36'h94000, 8'h04, "R5 16K granule index 13");
        probe(36'h90000, 8'h00, "R5 neighbour granule 12");
        probe(36'hC0000, 8'h03, "R6 4K granule index 24");
        probe(36'hFF000, 8'h05, "R6 4K granule index 87");

        // Window 0: WB over 1 MiB at 0x100000.
        cfg(3'd1, 0, 36'h0_0010_0006);
        cfg(3'd2, 0, 36'hF_FFF0_0800);
        probe(36'h150000, 8'h06, "R8 window match");
        // Window 1 written with enable clear.
        cfg(3'd1, 1, 36'h0_0020_0001);
        cfg(3'd2, 1, 36'hF_FFF0_0000);
        probe(36'h200000, 8'h00, "R8 disabled window ignored");
        cfg(3'd2, 1, 36'hF_FFF0_0800);
        probe(36'h200000, 8'h01, "R8 enabled window type from base low byte");

        // Overlaps, with default WC.
        cfg(3'd3, 0, 36'hC01);
        cfg(3'd1, 2, 36'h0_0000_0004);
        cfg(3'd2, 2, 36'hF_FFE0_0800);
        probe(36'h150000, 8'h04, "R9 WB with WT gives WT");
        probe(36'h050000, 8'h00, "R7 fixed wins over windows");
        cfg(3'd1, 3, 36'h0_0018_0005);
        cfg(3'd2, 3, 36'hF_FFF8_0800);
        probe(36'h190000, 8'h00, "R9 differing types give UC");
        cfg(3'd1, 4, 36'h0_0400_0000);
        cfg(3'd2, 4, 36'hF_FC00_0800);
        cfg(3'd1, 5, 36'h0_0400_0006);
        cfg(3'd2, 5, 36'hF_FC00_0800);
        probe(36'h4000000, 8'h00, "R9 UC dominates");
        cfg(3'd1, 6, 36'h0_0800_0006);
        cfg(3'd2, 6, 36'hF_FC00_0800);
        cfg(3'd1, 7, 36'h0_0800_0006);
        cfg(3'd2, 7, 36'hF_FC00_0800);
        probe(36'h8000000, 8'h06, "R9 equal types kept");
        probe(36'h300000, 8'h01, "R10 no match gives default");

        // Fixed enable clear: low address goes through windows.
        cfg(3'd3, 0, 36'h801);
        probe(36'h050000, 8'h04, "R7 fixed disabled uses windows");

        // Upper-memory limit.
        cfg(3'd4, 0, 36'h2_0000_0000);
        probe(36'h1_0000_0000, 8'h06, "R11 at 4 GiB gives WB");
        probe(36'h2_0000_0000, 8'h01, "R11 limit itself excluded");
        probe(36'h0_FFFF_F000, 8'h01, "R11 below 4 GiB excluded");

        // Back-to-back strobes.
        lookup(36'h150000, 8'h04, "R2 burst first");
        lookup(36'h300000, 8'h01, "R2 burst second");
        lookup(36'h8000000, 8'h06, "R2 burst third");
        idle();

        // Global disable.
        cfg(3'd3, 0, 36'h401);
        probe(36'h30000, 8'hFF, "R3 disabled fixed address");
        probe(36'h150000, 8'hFF, "R3 disabled window address");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all responses seen", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule